// File: doc/BRIEF.md
# RAMDAC Host Register Port and Palette Loader

This block is the host-facing write side of a RAMDAC. The host reaches it through four direct ports picked by a two-bit port number. Port 0 loads a shared 8-bit address register. Port 1 is the cursor data port, which is accepted and then discarded. Port 2 is an indirect window that writes the internal register the shared address selects. Port 3 takes palette colour bytes.

Palette bytes arrive as red, then green, then blue. A component counter tracks which byte comes next. When the blue byte lands, the block issues a one-cycle write strobe to an external 256-entry palette, carrying the current address and the colour with an opaque alpha byte. It then advances the address, wrapping from 255 to 0, so that a whole palette loads as one stream.

From the miscellaneous control register, the block decodes the pixel depth and the pixel clock divisor, and it flags a depth code that is not valid.

Top module: `ramdac_regport`

## Requirements
- R1: After reset, the address, the component index and the four indirect registers are 0, `palWe` is low, `pixBpp` reads 8, `clkDiv` reads 2 and `depthBad` is low.
- R2: A write to port 0 loads `wrData` into the address (seen on `curAddr` after the write edge) and returns the component index to red, abandoning any partly entered colour.
- R3: Port 3 writes are taken in the order red, green, blue. The write of blue makes `palWe` high for exactly the next cycle, with `palIdx` equal to the address and `palArgb` = {8'hFF, red, green, blue}.
- R4: After each committed entry the address increments by one, wrapping from 255 to 0.
- R5: A port 2 write stores `wrData` according to the address: 0x10 goes to `curPosHi`, 0x11 to `curPosLo`, 0x20 to `miscCtrl` and 0x21 to `dblBufCtrl`. The address and the component index are left unchanged.
- R6: A port 2 write at any other address changes no register.
- R7: A port 1 (cursor data) write changes no output, the address or the component index.
- R8: `miscCtrl[3:2]` selects the depth: 0 gives `pixBpp` 8, 1 gives 16, and 2 gives 32.
- R9: When `miscCtrl[3:2]` is 3, `depthBad` is high and `pixBpp` is 0.
- R10: `clkDiv` equals 2 to the power (`miscCtrl[7:6]` + 1), which gives 2, 4, 8 or 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Host write strobe, one write per cycle |
| wrPort | input | 2 | Direct port number (0 address, 1 cursor data, 2 indirect window, 3 palette) |
| wrData | input | 8 | Write data |
| curAddr | output | 8 | Shared address register |
| curPosHi | output | 8 | Cursor position, high byte |
| curPosLo | output | 8 | Cursor position, low byte |
| miscCtrl | output | 8 | Miscellaneous control register |
| dblBufCtrl | output | 8 | Double-buffer control register |
| pixBpp | output | 6 | Decoded bits per pixel (0 when invalid) |
| clkDiv | output | 5 | Decoded pixel clock divisor |
| depthBad | output | 1 | Invalid depth code present |
| palWe | output | 1 | Palette entry write strobe |
| palIdx | output | 8 | Palette entry index |
| palArgb | output | 32 | Palette entry, alpha in the top byte |

## Verification
Every register output, including `curAddr`, takes its new value at the clock edge that captures the write. The decoded depth, divisor and invalid flag follow combinationally from that same edge. The commit strobe and its index and colour are also registered at the edge that captures the blue byte, so they are valid for the one cycle after it.

The bench drives each write at a falling edge and samples only at the next falling edge. A scoreboard queue receives the expected entry at the moment the blue byte is driven. A monitor compares each `palWe` cycle against the head of that queue and reports any strobe that arrives with no entry expected.

// File: rtl/ramdac_pkg.sv
package ramdac_pkg;
  localparam int DATA_W = 8;
  localparam int PORT_W = 2;

  typedef enum logic [PORT_W-1:0] {
    PORT_ADDR  = 2'd0,
    PORT_CURS  = 2'd1,
    PORT_MULTI = 2'd2,
    PORT_PAL   = 2'd3
  } port_e;

  typedef struct packed {
    logic ldAddr;
    logic ldCurHi;
    logic ldCurLo;
    logic ldMisc;
    logic ldDbl;
    logic ldRed;
    logic ldGreen;
    logic commit;
  } strobe_t;
endpackage

// File: rtl/ramdac_ctrl.sv
module ramdac_ctrl
  import ramdac_pkg::*;
#(
  parameter logic [DATA_W-1:0] SEL_CUR_HI = 8'h10,
  parameter logic [DATA_W-1:0] SEL_CUR_LO = 8'h11,
  parameter logic [DATA_W-1:0] SEL_MISC   = 8'h20,
  parameter logic [DATA_W-1:0] SEL_DBL    = 8'h21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [PORT_W-1:0] wrPort,
  input  logic [DATA_W-1:0] addr,
  output strobe_t           stb
);
  localparam int COMP_N = 3;
  localparam int COMP_W = $clog2(COMP_N);

  logic [COMP_W-1:0] compIdx;
  port_e portSel;

  assign portSel = port_e'(wrPort);

  always_comb begin
    stb = '0;
    if (wrEn) begin
      unique case (portSel)
        PORT_ADDR:  stb.ldAddr = 1'b1;
        PORT_CURS:  ;
        PORT_MULTI: begin
          stb.ldCurHi = (addr == SEL_CUR_HI);
          stb.ldCurLo = (addr == SEL_CUR_LO);
          stb.ldMisc  = (addr == SEL_MISC);
          stb.ldDbl   = (addr == SEL_DBL);
        end
        PORT_PAL: begin
          stb.ldRed   = (compIdx == COMP_W'(0));
          stb.ldGreen = (compIdx == COMP_W'(1));
          stb.commit  = (compIdx == COMP_W'(COMP_N-1));
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) compIdx <= '0;
    else if (stb.ldAddr) compIdx <= '0;
    else if (stb.commit) compIdx <= '0;
    else if (stb.ldRed || stb.ldGreen) compIdx <= compIdx + COMP_W'(1);
  end

  // R3: the component index never leaves red/green/blue
  a_r3_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    compIdx <= COMP_W'(COMP_N-1));
  // R2: an address write restarts the colour sequence
  a_r2_addr_clears_idx: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldAddr |=> compIdx == '0);
  // R5: at most one indirect target per write
  a_r5_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ldCurHi, stb.ldCurLo, stb.ldMisc, stb.ldDbl}));
  // R7: a cursor-data write leaves the index alone
  a_r7_curs_no_idx: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portSel == PORT_CURS) |=> $stable(compIdx));
endmodule

// File: rtl/ramdac_datapath.sv
module ramdac_datapath
  import ramdac_pkg::*;
#(
  parameter int ALPHA_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       stb,
  input  logic [DATA_W-1:0]             wrData,
  output logic [DATA_W-1:0]             addr,
  output logic [DATA_W-1:0]             curPosHi,
  output logic [DATA_W-1:0]             curPosLo,
  output logic [DATA_W-1:0]             miscCtrl,
  output logic [DATA_W-1:0]             dblBufCtrl,
  output logic                          palWe,
  output logic [DATA_W-1:0]             palIdx,
  output logic [ALPHA_W+3*DATA_W-1:0]   palArgb
);
  localparam logic [ALPHA_W-1:0] OPAQUE = '1;

  logic [DATA_W-1:0] redHold, greenHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr       <= '0;
      curPosHi   <= '0;
      curPosLo   <= '0;
      miscCtrl   <= '0;
      dblBufCtrl <= '0;
      redHold    <= '0;
      greenHold  <= '0;
      palWe      <= 1'b0;
      palIdx     <= '0;
      palArgb    <= '0;
    end else begin
      palWe <= stb.commit;
      if (stb.ldAddr)  addr <= wrData;
      else if (stb.commit) addr <= addr + DATA_W'(1);
      if (stb.ldCurHi) curPosHi   <= wrData;
      if (stb.ldCurLo) curPosLo   <= wrData;
      if (stb.ldMisc)  miscCtrl   <= wrData;
      if (stb.ldDbl)   dblBufCtrl <= wrData;
      if (stb.ldRed)   redHold    <= wrData;
      if (stb.ldGreen) greenHold  <= wrData;
      if (stb.commit) begin
        palIdx  <= addr;
        palArgb <= {OPAQUE, redHold, greenHold, wrData};
      end
    end
  end

  // R4: after a commit the address sits one past the committed index
  a_r4_addr_advanced: assert property (@(posedge clk) disable iff (!rstN)
    palWe |-> addr == palIdx + DATA_W'(1));
  // R3: a committed entry is always opaque
  a_r3_alpha_opaque: assert property (@(posedge clk) disable iff (!rstN)
    palWe |-> palArgb[ALPHA_W+3*DATA_W-1 -: ALPHA_W] == OPAQUE);
  // R6: control register moves only on its own strobe
  a_r6_misc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ldMisc |=> $stable(miscCtrl));
  a_r6_dbl_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ldDbl |=> $stable(dblBufCtrl));
endmodule

// File: rtl/ramdac_regport.sv
module ramdac_regport
  import ramdac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrPort,
  input  logic [7:0]  wrData,
  output logic [7:0]  curAddr,
  output logic [7:0]  curPosHi,
  output logic [7:0]  curPosLo,
  output logic [7:0]  miscCtrl,
  output logic [7:0]  dblBufCtrl,
  output logic [5:0]  pixBpp,
  output logic [4:0]  clkDiv,
  output logic        depthBad,
  output logic        palWe,
  output logic [7:0]  palIdx,
  output logic [31:0] palArgb
);
  localparam int DEPTH_LSB = 2;
  localparam int DIV_LSB   = 6;
  localparam logic [1:0] DEPTH_BAD_CODE = 2'd3;

  strobe_t stb;
  logic [1:0] depthCode, divCode;

  ramdac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrPort(wrPort),
    .addr(curAddr), .stb(stb)
  );

  ramdac_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .addr(curAddr), .curPosHi(curPosHi), .curPosLo(curPosLo),
    .miscCtrl(miscCtrl), .dblBufCtrl(dblBufCtrl),
    .palWe(palWe), .palIdx(palIdx), .palArgb(palArgb)
  );

  assign depthCode = miscCtrl[DEPTH_LSB +: 2];
  assign divCode   = miscCtrl[DIV_LSB +: 2];
  assign depthBad  = (depthCode == DEPTH_BAD_CODE);
  assign pixBpp    = depthBad ? 6'd0 : (6'd8 << depthCode);
  assign clkDiv    = 5'd2 << divCode;

  // R9: the flag and a zero depth always go together
  a_r9_bad_zero: assert property (@(posedge clk) disable iff (!rstN)
    depthBad == (pixBpp == 6'd0));
  // R10: exactly one divisor bit is set
  a_r10_div_pow2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(clkDiv) == 1 && !clkDiv[0]);
endmodule

// File: tb/sim_ramdac_regport.sv
module sim_ramdac_regport;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [1:0] wrPort = '0;
  logic [7:0] wrData = '0;
  logic [7:0] curAddr, curPosHi, curPosLo, miscCtrl, dblBufCtrl, palIdx;
  logic [5:0] pixBpp;
  logic [4:0] clkDiv;
  logic depthBad, palWe;
  logic [31:0] palArgb;

  int nChk = 0, nBad = 0;
  logic [39:0] expQ[$];
  logic [7:0] modelAddr = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ramdac_regport u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] p, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrPort = p; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setAddr(logic [7:0] a);
    wr(2'd0, a);
    modelAddr = a;
  endtask

  task automatic loadEntry(logic [7:0] r, logic [7:0] g, logic [7:0] b);
    wr(2'd3, r);
    wr(2'd3, g);
    expQ.push_back({modelAddr, 8'hFF, r, g, b});
    wr(2'd3, b);
    modelAddr = modelAddr + 8'd1;
  endtask

  // scoreboard monitor (R3, R4)
  always @(negedge clk) begin
    if (rstN && palWe) begin
      if (expQ.size() == 0) chk("R3 unexpected palWe", 32'd1, 32'd0);
      else begin
        logic [39:0] e;
        e = expQ.pop_front();
        chk("R4 palIdx", {24'd0, palIdx}, {24'd0, e[39:32]});
        chk("R3 palArgb", palArgb, e[31:0]);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 addr", {24'd0, curAddr}, 0);
    chk("R1 misc", {24'd0, miscCtrl}, 0);
    chk("R1 bpp", {26'd0, pixBpp}, 8);
    chk("R1 div", {27'd0, clkDiv}, 2);
    chk("R1 palWe", {31'd0, palWe}, 0);
    chk("R1 bad", {31'd0, depthBad}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 address load
    setAddr(8'h40);
    chk("R2 addr", {24'd0, curAddr}, 32'h40);
    // R3 basic entries, R4 increment
    loadEntry(8'h11, 8'h22, 8'h33);
    chk("R4 addr inc", {24'd0, curAddr}, 32'h41);
    loadEntry(8'hA0, 8'hB1, 8'hC2);
    chk("R4 addr inc2", {24'd0, curAddr}, 32'h42);
    // R2 partial sequence abandoned on address write
    wr(2'd3, 8'hEE);
    wr(2'd3, 8'hDD);
    setAddr(8'h07);
    loadEntry(8'h01, 8'h02, 8'h03);
    // R4 wrap
    setAddr(8'hFF);
    loadEntry(8'h55, 8'h66, 8'h77);
    chk("R4 wrap", {24'd0, curAddr}, 0);
    // R7 cursor data mid-sequence ignored
    setAddr(8'h20);
    wr(2'd3, 8'h9A);
    wr(2'd1, 8'hC3);
    chk("R7 addr", {24'd0, curAddr}, 32'h20);
    chk("R7 misc", {24'd0, miscCtrl}, 0);
    chk("R7 palWe", {31'd0, palWe}, 0);
    wr(2'd3, 8'h9B);
    expQ.push_back({8'h20, 8'hFF, 8'h9A, 8'h9B, 8'h9C});
    wr(2'd3, 8'h9C);
    modelAddr = 8'h21;

    // R5 indirect registers
    setAddr(8'h10); wr(2'd2, 8'hA1);
    chk("R5 curHi", {24'd0, curPosHi}, 32'hA1);
    chk("R5 addr kept", {24'd0, curAddr}, 32'h10);
    setAddr(8'h11); wr(2'd2, 8'hB2);
    chk("R5 curLo", {24'd0, curPosLo}, 32'hB2);
    setAddr(8'h21); wr(2'd2, 8'hC4);
    chk("R5 dbl", {24'd0, dblBufCtrl}, 32'hC4);
    // R5 index kept across indirect write
    wr(2'd3, 8'h10);
    wr(2'd2, 8'hC5);
    wr(2'd3, 8'h20);
    expQ.push_back({8'h21, 8'hFF, 8'h10, 8'h20, 8'h30});
    wr(2'd3, 8'h30);
    chk("R5 dbl2", {24'd0, dblBufCtrl}, 32'hC5);
    setAddr(8'h20); wr(2'd2, 8'h00);
    chk("R8 bpp8", {26'd0, pixBpp}, 8);
    chk("R10 div2", {27'd0, clkDiv}, 2);
    wr(2'd2, 8'h44);   // depth 1, div field 1
    chk("R5 misc", {24'd0, miscCtrl}, 32'h44);
    chk("R8 bpp16", {26'd0, pixBpp}, 16);
    chk("R10 div4", {27'd0, clkDiv}, 4);
    wr(2'd2, 8'h88);   // depth 2, div field 2
    chk("R8 bpp32", {26'd0, pixBpp}, 32);
    chk("R10 div8", {27'd0, clkDiv}, 8);
    chk("R9 ok", {31'd0, depthBad}, 0);
    wr(2'd2, 8'hCC);   // depth 3, div field 3
    chk("R9 bad", {31'd0, depthBad}, 1);
    chk("R9 bpp0", {26'd0, pixBpp}, 0);
    chk("R10 div16", {27'd0, clkDiv}, 16);

    // R6 unknown indirect addresses
    foreach (miscCtrl[i]) begin end
    setAddr(8'h22); wr(2'd2, 8'h5A);
    setAddr(8'h00); wr(2'd2, 8'h5B);
    setAddr(8'h12); wr(2'd2, 8'h5C);
    chk("R6 curHi", {24'd0, curPosHi}, 32'hA1);
    chk("R6 curLo", {24'd0, curPosLo}, 32'hB2);
    chk("R6 misc", {24'd0, miscCtrl}, 32'hCC);
    chk("R6 dbl", {24'd0, dblBufCtrl}, 32'hC5);

    repeat (3) @(negedge clk);
    chk("R3 queue drained", expQ.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule